// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the software-visible front of an SMBus host controller. It sits behind a byte-wide synchronous access port. It holds the command, target-address, two data bytes, a control byte and a status byte. It also holds a 32-entry block buffer, which software reaches through a single data port that advances by itself. A separate transaction engine drives the bus. It receives every stored register through dedicated outputs, and it returns status, data bytes and buffer entries through its own write ports.

Software writes the control byte with bit 6 set to start a transaction. The block answers with a one-cycle start pulse to the engine. The engine reports its progress by loading the status byte. Software acknowledges events by writing ones to the status bits it wants to clear.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register, every buffer entry, the buffer pointer, `start_o` and `rdata_o` are zero.
- R2: The byte offsets are as follows: status 0x00, control 0x02, command 0x03, target address 0x04, data byte 0 at 0x05, data byte 1 at 0x06 and block data port 0x07. A read of any other offset returns 0x00, and a write to any other offset changes no register.
- R3: A host write to status clears each status bit where the written byte has a 1 and keeps the other bits. It also sets the buffer pointer to 0.
- R4: A host write to control stores all 8 bits, which appear on `ctl_o`. A host read of control returns the stored value ANDed with 0x1F and sets the buffer pointer to 0.
- R5: `start_o` is high for exactly the one cycle after a control write whose bit 6 is 1. It stays low at all other times.
- R6: Each host read or write of the block data port accesses the buffer entry at the pointer and then advances the pointer. After entry 31 the pointer returns to 0.
- R7: `rdata_o` takes the read value on the clock edge that samples `rd_en_i`, so it is valid one cycle after the strobe. It holds its value in every cycle without an accepted read.
- R8: In the same cycle as a host write, an engine write to status, data byte 0, data byte 1 or a buffer entry takes precedence for that storage. The pointer side effects of the host access still happen.
- R9: If `wr_en_i` and `rd_en_i` are both high in a cycle, only the write takes effect. The read has no side effect, and `rdata_o` is not updated.
- R10: `eng_buf_o` shows, without a clock delay, the buffer entry selected by `eng_buf_idx_i`.
- R11: Status bit positions are: 0 busy, 1 interrupt, 2 device error, 3 bus error, 4 failed, 5 alert, 6 in use, 7 byte done. The block stores and clears these bits but gives none of them any other meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | AW | Host byte offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, registered |
| start_o | output | 1 | One-cycle transaction start pulse |
| sts_o | output | 8 | Status byte |
| ctl_o | output | 8 | Control byte |
| cmd_o | output | 8 | Command byte |
| tgt_addr_o | output | 8 | Target address byte |
| data0_o | output | 8 | Data byte 0 |
| data1_o | output | 8 | Data byte 1 |
| eng_sts_we_i | input | 1 | Engine status load enable |
| eng_sts_i | input | 8 | Engine status value |
| eng_d0_we_i | input | 1 | Engine data byte 0 load enable |
| eng_d0_i | input | 8 | Engine data byte 0 value |
| eng_d1_we_i | input | 1 | Engine data byte 1 load enable |
| eng_d1_i | input | 8 | Engine data byte 1 value |
| eng_buf_we_i | input | 1 | Engine buffer write enable |
| eng_buf_idx_i | input | PW | Engine buffer index |
| eng_buf_i | input | 8 | Engine buffer write data |
| eng_buf_o | output | 8 | Buffer entry at engine index |

## Verification
The assertions check the following on every cycle: the one-cycle start pulse and its cause, write-one-to-clear of status, engine precedence on status and data byte 0, storage of control writes, the hold of `rdata_o` between reads, and that writes to unmapped offsets leave the software-only registers unchanged. The buffer pointer is internal, so the bench has to show its behaviour through ordered sequences of port accesses. These sequences cover the wrap after entry 31, the pointer reset on a status write and on a control read, the read ignored when it collides with a write, and same-index collisions between engine and host writes to the buffer.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int unsigned OFS_STS = 0;
  localparam int unsigned OFS_CTL = 2;
  localparam int unsigned OFS_CMD = 3;
  localparam int unsigned OFS_TGT = 4;
  localparam int unsigned OFS_D0  = 5;
  localparam int unsigned OFS_D1  = 6;
  localparam int unsigned OFS_BLK = 7;

  localparam int unsigned CTL_GO_BIT   = 6;
  localparam logic [7:0]  CTL_RD_MASK  = 8'h1f;

  typedef struct packed {
    logic byte_done;
    logic in_use;
    logic alert;
    logic failed;
    logic bus_err;
    logic dev_err;
    logic intr;
    logic busy;
  } sts_t;
endpackage

// File: rtl/smb_ctrl_regs.sv
module smb_ctrl_regs
  import smb_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_sts_i,
  input  logic       wr_ctl_i,
  input  logic       wr_cmd_i,
  input  logic       wr_tgt_i,
  input  logic       wr_d0_i,
  input  logic       wr_d1_i,
  input  logic [7:0] wdata_i,
  input  logic       eng_sts_we_i,
  input  logic [7:0] eng_sts_i,
  input  logic       eng_d0_we_i,
  input  logic [7:0] eng_d0_i,
  input  logic       eng_d1_we_i,
  input  logic [7:0] eng_d1_i,
  output logic [7:0] sts_o,
  output logic [7:0] ctl_o,
  output logic [7:0] cmd_o,
  output logic [7:0] tgt_o,
  output logic [7:0] d0_o,
  output logic [7:0] d1_o,
  output logic       start_o
);
  sts_t       sts_q;
  logic [7:0] ctl_q, cmd_q, tgt_q, d0_q, d1_q;
  logic       start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= '0;
      ctl_q   <= '0;
      cmd_q   <= '0;
      tgt_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_ctl_i & wdata_i[CTL_GO_BIT];
      if (wr_ctl_i) ctl_q <= wdata_i;
      if (wr_cmd_i) cmd_q <= wdata_i;
      if (wr_tgt_i) tgt_q <= wdata_i;
      // engine ports win over the host
      if (eng_sts_we_i)  sts_q <= sts_t'(eng_sts_i);
      else if (wr_sts_i) sts_q <= sts_t'(sts_q & ~wdata_i);
      if (eng_d0_we_i)   d0_q <= eng_d0_i;
      else if (wr_d0_i)  d0_q <= wdata_i;
      if (eng_d1_we_i)   d1_q <= eng_d1_i;
      else if (wr_d1_i)  d1_q <= wdata_i;
    end
  end

  assign sts_o   = sts_q;
  assign ctl_o   = ctl_q;
  assign cmd_o   = cmd_q;
  assign tgt_o   = tgt_q;
  assign d0_o    = d0_q;
  assign d1_o    = d1_q;
  assign start_o = start_q;
endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic          host_re_i,
  input  logic          ptr_clr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    host_rdata_o,
  input  logic          eng_we_i,
  input  logic [PW-1:0] eng_idx_i,
  input  logic [7:0]    eng_wdata_i,
  output logic [7:0]    eng_rdata_o
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] ptr_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[i] <= '0;
      else if (eng_we_i && eng_idx_i == PW'(i))       mem[i] <= eng_wdata_i;
      else if (host_we_i && ptr_q == PW'(i))          mem[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ptr_q <= '0;
    else if (ptr_clr_i)              ptr_q <= '0;
    else if (host_we_i || host_re_i) ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign host_rdata_o = mem[ptr_q];
  assign eng_rdata_o  = mem[eng_idx_i];
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int AW = 6,
  parameter int BUF_DEPTH = 32,
  localparam int PW = $clog2(BUF_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          start_o,
  output logic [7:0]    sts_o,
  output logic [7:0]    ctl_o,
  output logic [7:0]    cmd_o,
  output logic [7:0]    tgt_addr_o,
  output logic [7:0]    data0_o,
  output logic [7:0]    data1_o,
  input  logic          eng_sts_we_i,
  input  logic [7:0]    eng_sts_i,
  input  logic          eng_d0_we_i,
  input  logic [7:0]    eng_d0_i,
  input  logic          eng_d1_we_i,
  input  logic [7:0]    eng_d1_i,
  input  logic          eng_buf_we_i,
  input  logic [PW-1:0] eng_buf_idx_i,
  input  logic [7:0]    eng_buf_i,
  output logic [7:0]    eng_buf_o
);
  logic       rd_act;
  logic       hit_sts, hit_ctl, hit_cmd, hit_tgt, hit_d0, hit_d1, hit_blk;
  logic [7:0] blk_rdata, rd_mux, rdata_q;

  assign hit_sts = addr_i == AW'(OFS_STS);
  assign hit_ctl = addr_i == AW'(OFS_CTL);
  assign hit_cmd = addr_i == AW'(OFS_CMD);
  assign hit_tgt = addr_i == AW'(OFS_TGT);
  assign hit_d0  = addr_i == AW'(OFS_D0);
  assign hit_d1  = addr_i == AW'(OFS_D1);
  assign hit_blk = addr_i == AW'(OFS_BLK);

  // a write in the same cycle suppresses the read
  assign rd_act = rd_en_i & ~wr_en_i;

  smb_ctrl_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_sts_i     (wr_en_i & hit_sts),
    .wr_ctl_i     (wr_en_i & hit_ctl),
    .wr_cmd_i     (wr_en_i & hit_cmd),
    .wr_tgt_i     (wr_en_i & hit_tgt),
    .wr_d0_i      (wr_en_i & hit_d0),
    .wr_d1_i      (wr_en_i & hit_d1),
    .wdata_i      (wdata_i),
    .eng_sts_we_i (eng_sts_we_i),
    .eng_sts_i    (eng_sts_i),
    .eng_d0_we_i  (eng_d0_we_i),
    .eng_d0_i     (eng_d0_i),
    .eng_d1_we_i  (eng_d1_we_i),
    .eng_d1_i     (eng_d1_i),
    .sts_o        (sts_o),
    .ctl_o        (ctl_o),
    .cmd_o        (cmd_o),
    .tgt_o        (tgt_addr_o),
    .d0_o         (data0_o),
    .d1_o         (data1_o),
    .start_o      (start_o)
  );

  smb_blk_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (wr_en_i & hit_blk),
    .host_re_i    (rd_act & hit_blk),
    .ptr_clr_i    ((wr_en_i & hit_sts) | (rd_act & hit_ctl)),
    .wdata_i      (wdata_i),
    .host_rdata_o (blk_rdata),
    .eng_we_i     (eng_buf_we_i),
    .eng_idx_i    (eng_buf_idx_i),
    .eng_wdata_i  (eng_buf_i),
    .eng_rdata_o  (eng_buf_o)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_sts) rd_mux = sts_o;
    if (hit_ctl) rd_mux = ctl_o & CTL_RD_MASK;
    if (hit_cmd) rd_mux = cmd_o;
    if (hit_tgt) rd_mux = tgt_addr_o;
    if (hit_d0)  rd_mux = data0_o;
    if (hit_d1)  rd_mux = data1_o;
    if (hit_blk) rd_mux = blk_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_act) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk
  import smb_host_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          start_o,
  input logic [7:0]    sts_o,
  input logic [7:0]    ctl_o,
  input logic [7:0]    cmd_o,
  input logic [7:0]    tgt_addr_o,
  input logic          eng_sts_we_i,
  input logic [7:0]    eng_sts_i,
  input logic          eng_d0_we_i,
  input logic [7:0]    eng_d0_i,
  input logic [7:0]    data0_o
);
  logic go_wr, sts_wr, unmapped;
  assign go_wr    = wr_en_i && addr_i == AW'(OFS_CTL) && wdata_i[CTL_GO_BIT];
  assign sts_wr   = wr_en_i && addr_i == AW'(OFS_STS);
  assign unmapped = addr_i == AW'(1) || addr_i > AW'(OFS_BLK);

  a_r5_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_wr |=> start_o);
  a_r5_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(go_wr));
  a_r3_sts_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && !eng_sts_we_i) |=> sts_o == ($past(sts_o) & ~$past(wdata_i)));
  a_r8_eng_sts_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_sts_we_i |=> sts_o == $past(eng_sts_i));
  a_r8_eng_d0_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_d0_we_i |=> data0_o == $past(eng_d0_i));
  a_r4_ctl_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(OFS_CTL)) |=> ctl_o == $past(wdata_i));
  a_r7_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !wr_en_i) |=> $stable(rdata_o));
  a_r2_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && unmapped) |=> ($stable(ctl_o) && $stable(cmd_o) && $stable(tgt_addr_o)));
endmodule

bind smb_host_regs smb_host_regs_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .start_o      (start_o),
  .sts_o        (sts_o),
  .ctl_o        (ctl_o),
  .cmd_o        (cmd_o),
  .tgt_addr_o   (tgt_addr_o),
  .eng_sts_we_i (eng_sts_we_i),
  .eng_sts_i    (eng_sts_i),
  .eng_d0_we_i  (eng_d0_we_i),
  .eng_d0_i     (eng_d0_i),
  .data0_o      (data0_o)
);

// File: tb/tb_smb_host_regs.sv
module tb_smb_host_regs;
  localparam int AW = 6;
  localparam int DEPTH = 32;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_o, sts_o, ctl_o, cmd_o, tgt_addr_o, data0_o, data1_o, eng_buf_o;
  logic start_o;
  logic eng_sts_we = 1'b0, eng_d0_we = 1'b0, eng_d1_we = 1'b0, eng_buf_we = 1'b0;
  logic [7:0] eng_sts = '0, eng_d0 = '0, eng_d1 = '0, eng_buf = '0;
  logic [PW-1:0] eng_idx = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mbuf [DEPTH];
  int mptr = 0;

  always #10 clk = ~clk;

  smb_host_regs #(.AW(AW), .BUF_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .start_o(start_o),
    .sts_o(sts_o), .ctl_o(ctl_o), .cmd_o(cmd_o), .tgt_addr_o(tgt_addr_o),
    .data0_o(data0_o), .data1_o(data1_o),
    .eng_sts_we_i(eng_sts_we), .eng_sts_i(eng_sts),
    .eng_d0_we_i(eng_d0_we), .eng_d0_i(eng_d0),
    .eng_d1_we_i(eng_d1_we), .eng_d1_i(eng_d1),
    .eng_buf_we_i(eng_buf_we), .eng_buf_idx_i(eng_idx), .eng_buf_i(eng_buf),
    .eng_buf_o(eng_buf_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void adv_ptr();
    mptr = (mptr == DEPTH - 1) ? 0 : mptr + 1;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 0) mptr = 0;
    if (a == 7) begin mbuf[mptr] = d; adv_ptr(); end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata_o;
    if (a == 2) mptr = 0;
    if (a == 7) adv_ptr();
  endtask

  task automatic eng_set_sts(input logic [7:0] v);
    @(negedge clk);
    eng_sts_we = 1'b1; eng_sts = v;
    @(negedge clk);
    eng_sts_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, exp;
    for (int i = 0; i < DEPTH; i++) mbuf[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sts", sts_o, 8'h00);  chk("R1 ctl", ctl_o, 8'h00);
    chk("R1 cmd", cmd_o, 8'h00);  chk("R1 tgt", tgt_addr_o, 8'h00);
    chk("R1 d0", data0_o, 8'h00); chk("R1 d1", data1_o, 8'h00);
    chk("R1 start", {7'd0, start_o}, 8'h00);
    chk("R1 rdata", rdata_o, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      eng_idx = PW'(i); #1;
      chk("R1 R10 buf", eng_buf_o, 8'h00);
    end
    for (int i = 0; i < 4; i++) begin
      rd(7, v); chk("R1 blk read", v, 8'h00);
    end

    // R2 plain registers, full value sweep
    for (int x = 0; x < 256; x++) begin
      wr(3, 8'(x)); wr(4, 8'(x ^ 8'hA5)); wr(5, 8'(x + 1)); wr(6, 8'(~x));
      chk("R2 cmd_o", cmd_o, 8'(x));
      chk("R2 tgt_o", tgt_addr_o, 8'(x ^ 8'hA5));
      rd(3, v); chk("R2 cmd", v, 8'(x));
      rd(4, v); chk("R2 tgt", v, 8'(x ^ 8'hA5));
      rd(5, v); chk("R2 d0", v, 8'(x + 1));
      rd(6, v); chk("R2 d1", v, 8'(~x));
    end

    // R4 R5 control sweep
    for (int x = 0; x < 256; x++) begin
      wr(2, 8'(x));
      chk("R5 pulse", {7'd0, start_o}, {7'd0, 1'(x >> 6)});
      chk("R4 ctl_o", ctl_o, 8'(x));
      @(negedge clk);
      chk("R5 single cycle", {7'd0, start_o}, 8'h00);
      rd(2, v); chk("R4 ctl read mask", v, 8'(x) & 8'h1f);
    end

    // R2 unmapped offsets
    wr(3, 8'h5A); wr(4, 8'hC3); wr(2, 8'h1B); wr(5, 8'h77); wr(6, 8'h88);
    for (int a = 1; a < 64; a++) begin
      if (a >= 2 && a <= 7) continue;
      wr(a, 8'hFF);
      chk("R2 unmapped no start", {7'd0, start_o}, 8'h00);
      rd(a, v); chk("R2 unmapped read", v, 8'h00);
    end
    rd(3, v); chk("R2 cmd kept", v, 8'h5A);
    rd(4, v); chk("R2 tgt kept", v, 8'hC3);
    rd(5, v); chk("R2 d0 kept", v, 8'h77);
    rd(6, v); chk("R2 d1 kept", v, 8'h88);
    rd(2, v); chk("R2 ctl kept", v, 8'h1B);
    rd(0, v); chk("R2 sts kept", v, 8'h00);

    // R3 R11 write-one-to-clear sweep
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 8; m++) begin
        logic [7:0] mask;
        case (m)
          0: mask = 8'h00; 1: mask = 8'hFF; 2: mask = 8'h0F; 3: mask = 8'hF0;
          4: mask = 8'h55; 5: mask = 8'hAA; 6: mask = 8'h81; default: mask = 8'h7E;
        endcase
        eng_set_sts(8'(s * 17));
        wr(0, mask);
        exp = 8'(s * 17) & ~mask;
        chk("R3 sts_o w1c", sts_o, exp);
        rd(0, v); chk("R3 R11 sts read", v, exp);
      end
    end

    // R6 block port: 40 writes wrap over 32 entries
    rd(2, v);
    for (int i = 0; i < 40; i++) wr(7, 8'(i * 29 + 5));
    for (int i = 0; i < DEPTH; i++) begin
      eng_idx = PW'(i); #1;
      chk("R6 R10 buf content", eng_buf_o, mbuf[i]);
    end
    rd(2, v);
    for (int i = 0; i < 40; i++) begin
      exp = mbuf[mptr];
      rd(7, v); chk("R6 blk read wrap", v, exp);
    end

    // R3 status write resets pointer
    rd(2, v);
    for (int i = 0; i < 3; i++) rd(7, v);
    wr(0, 8'h00);
    rd(7, v); chk("R3 ptr reset by sts write", v, mbuf[0]);

    // R7 hold between reads
    rd(3, v);
    repeat (4) @(negedge clk);
    chk("R7 rdata hold", rdata_o, 8'h5A);

    // R9 simultaneous write and read of control: read ignored
    rd(2, v);
    for (int i = 0; i < 3; i++) rd(7, v);
    exp = rdata_o;
    @(negedge clk);
    addr = AW'(2); wdata = 8'h0C; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 rdata not updated", rdata_o, exp);
    chk("R9 write done", ctl_o, 8'h0C);
    rd(7, v); chk("R9 ptr untouched", v, mbuf[3]);

    // R8 engine precedence
    @(negedge clk);
    addr = AW'(5); wdata = 8'h11; wr_en = 1'b1; eng_d0_we = 1'b1; eng_d0 = 8'h22;
    @(negedge clk);
    wr_en = 1'b0; eng_d0_we = 1'b0;
    rd(5, v); chk("R8 d0", v, 8'h22);
    @(negedge clk);
    addr = AW'(6); wdata = 8'h33; wr_en = 1'b1; eng_d1_we = 1'b1; eng_d1 = 8'h44;
    @(negedge clk);
    wr_en = 1'b0; eng_d1_we = 1'b0;
    rd(6, v); chk("R8 d1", v, 8'h44);
    eng_set_sts(8'h00);
    @(negedge clk);
    addr = AW'(0); wdata = 8'hFF; wr_en = 1'b1; eng_sts_we = 1'b1; eng_sts = 8'h84;
    @(negedge clk);
    wr_en = 1'b0; eng_sts_we = 1'b0; mptr = 0;
    chk("R8 R11 sts", sts_o, 8'h84);
    rd(2, v);
    for (int i = 0; i < 9; i++) rd(7, v);
    @(negedge clk);
    addr = AW'(7); wdata = 8'h12; wr_en = 1'b1;
    eng_buf_we = 1'b1; eng_idx = PW'(9); eng_buf = 8'hE7;
    @(negedge clk);
    wr_en = 1'b0; eng_buf_we = 1'b0;
    mbuf[9] = 8'hE7; adv_ptr();
    chk("R8 buf engine wins", eng_buf_o, 8'hE7);
    rd(7, v); chk("R8 ptr advanced", v, mbuf[10]);
    rd(2, v);
    for (int i = 0; i < 9; i++) rd(7, v);
    rd(7, v); chk("R8 buf host view", v, 8'hE7);

    finish_run();
  end
endmodule